// File: doc/BRIEF.md
# Receive Byte-Pair Word Packer

The packer sits on the receive side of a network port, behind the line decoder and ahead of a 16-bit client. A byte stream enters at the byte clock. Within a frame the byte-valid input stays high for consecutive cycles. After the last byte comes a one-cycle good or bad verdict. The packer joins consecutive bytes into halfwords and hands them out at half the byte rate, paced by a clock enable that toggles on every byte clock.

The halfword has two qualifiers. A whole-word valid covers the frame as a whole. An upper-half valid tells the client whether bits [15:8] hold a byte. When a frame carries an odd number of bytes, the final byte goes out alone on the low half. The upper-half valid drops for that final word while the word valid stays high. The verdict is then presented as a one-word-cycle pulse once the data has been delivered.

Top module: `rxp_frame_packer`

## Requirements
- R1: While reset is held and immediately after it, every output is zero and `word_tick` is low.
- R2: `word_tick` inverts on every byte clock. The word outputs (`out_data`, `out_vld`, `out_hi_vld`, `out_good`, `out_bad`) change only at a rising edge that closes a cycle in which `word_tick` was high.
- R3: In each delivered word, the byte received earlier sits in bits [7:0] and the byte received next sits in bits [15:8].
- R4: The pairing restarts with every frame. The first byte of a frame always appears in bits [7:0] of that frame's first word, whatever the frame's alignment to `word_tick`.
- R5: For a frame of even length, `out_hi_vld` is high on every word that has `out_vld` high, and both fall in the same word cycle.
- R6: For a frame of odd length, the last word has `out_vld` high, `out_hi_vld` low, the final byte in bits [7:0] and zero in bits [15:8]. `out_hi_vld` is never high without `out_vld`.
- R7: A frame of N bytes yields exactly ceil(N/2) words on consecutive word cycles, with no gap in `out_vld`.
- R8: Each frame produces exactly one verdict pulse, one word cycle long, in the first word cycle after the frame's last word in which `out_vld` is low. `in_good` maps to `out_good` and `in_bad` maps to `out_bad`.
- R9: `out_good` and `out_bad` are never high together. If `in_good` and `in_bad` arrive together, the frame is reported bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte valid, high for consecutive cycles across a frame |
| in_byte | input | 8 | Received byte |
| in_good | input | 1 | One-cycle pulse in the cycle after the last byte: frame good |
| in_bad | input | 1 | One-cycle pulse in the cycle after the last byte: frame bad |
| word_tick | output | 1 | Half-rate enable; the word outputs update at the edge ending a high cycle |
| out_data | output | 16 | Packed halfword |
| out_vld | output | 1 | Word carries frame data |
| out_hi_vld | output | 1 | Bits [15:8] carry a byte |
| out_good | output | 1 | One-word-cycle good-frame pulse |
| out_bad | output | 1 | One-word-cycle bad-frame pulse |

## Verification
The bench sweeps frame lengths 1 to 12 at both alignments of the frame start to `word_tick`. It uses both verdicts, and a few frames carry both verdict inputs at once. It goes after four faults. An odd tail that keeps `out_hi_vld` high would present a stale upper byte. A packer that does not restart its pairing would put the first byte of the next frame in the upper half. A single staging slot that drops a word at a particular alignment would leave `out_vld` with a gap or give the wrong word count. A verdict issued together with the last word, or issued twice, would break the one-pulse-after-data rule. On every byte clock it also checks that nothing changes in the middle of a word cycle.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        FS_NONE = 2'd0,
        FS_GOOD = 2'd1,
        FS_BAD  = 2'd2
    } fstat_e;

    // A bad verdict dominates when both inputs pulse together.
    function automatic fstat_e fstat_pick(input logic good, input logic bad);
        if (bad)       return FS_BAD;
        else if (good) return FS_GOOD;
        else           return FS_NONE;
    endfunction

endpackage

// File: rtl/rxp_tick.sv
module rxp_tick (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    typedef struct packed {
        logic ph;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.ph;

endmodule

// File: rtl/rxp_pair.sv
module rxp_pair #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic                consume,
    output logic                pend_vld,
    output logic [2*BYTE_W-1:0] pend_word,
    output logic                pend_hi,
    output logic                busy
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic              have_lo;
        logic              prev_vld;
        logic              pvld;
        logic              phi;
        logic [WORD_W-1:0] pword;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     push;

    always_comb begin
        st_d          = st_q;
        push          = 1'b0;
        st_d.prev_vld = in_vld;
        if (consume) st_d.pvld = 1'b0;
        if (in_vld) begin
            if (!st_q.prev_vld || !st_q.have_lo) begin
                // frame start or even position: byte goes to the low half
                st_d.lo      = in_byte;
                st_d.have_lo = 1'b1;
            end else begin
                st_d.pword   = {in_byte, st_q.lo};
                st_d.phi     = 1'b1;
                st_d.pvld    = 1'b1;
                st_d.have_lo = 1'b0;
                push         = 1'b1;
            end
        end else if (st_q.have_lo) begin
            // odd tail: lone byte on the low half, upper half cleared
            st_d.pword   = {{BYTE_W{1'b0}}, st_q.lo};
            st_d.phi     = 1'b0;
            st_d.pvld    = 1'b1;
            st_d.have_lo = 1'b0;
            push         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_vld  = st_q.pvld;
    assign pend_word = st_q.pword;
    assign pend_hi   = st_q.phi;
    assign busy      = st_q.have_lo | st_q.pvld;

    // R7: the single staging slot is never overwritten before delivery
    a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.pvld) |-> consume);

endmodule

// File: rtl/rxp_emit.sv
module rxp_emit
    import rxp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                pend_vld,
    input  logic [2*BYTE_W-1:0] pend_word,
    input  logic                pend_hi,
    input  logic                busy,
    input  logic                in_good,
    input  logic                in_bad,
    output logic                consume,
    output logic [2*BYTE_W-1:0] out_data,
    output logic                out_vld,
    output logic                out_hi_vld,
    output logic                out_good,
    output logic                out_bad
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              vld;
        logic              hi;
        logic              good;
        logic              bad;
        fstat_e            stat;
    } emit_st_t;

    emit_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        consume = tick && pend_vld;
        if (tick) begin
            st_d.good = 1'b0;
            st_d.bad  = 1'b0;
            if (pend_vld) begin
                st_d.data = pend_word;
                st_d.vld  = 1'b1;
                st_d.hi   = pend_hi;
            end else begin
                st_d.vld = 1'b0;
                st_d.hi  = 1'b0;
                if (st_q.stat != FS_NONE && !busy) begin
                    st_d.good = (st_q.stat == FS_GOOD);
                    st_d.bad  = (st_q.stat == FS_BAD);
                    st_d.stat = FS_NONE;
                end
            end
        end
        if (in_good || in_bad) st_d.stat = fstat_pick(in_good, in_bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data   = st_q.data;
    assign out_vld    = st_q.vld;
    assign out_hi_vld = st_q.hi;
    assign out_good   = st_q.good;
    assign out_bad    = st_q.bad;

    // R2: word outputs hold across the byte cycle between word edges
    a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({st_q.data, st_q.vld, st_q.hi, st_q.good, st_q.bad}));

    // R6: the upper-half qualifier never stands without the word qualifier
    a_r6_hi_within_vld: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hi |-> st_q.vld);

    // R8: a verdict is never shown alongside a data word
    a_r8_verdict_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.good || st_q.bad) |-> !st_q.vld);

    // R9: verdicts are mutually exclusive
    a_r9_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.good && st_q.bad));

endmodule

// File: rtl/rxp_frame_packer.sv
module rxp_frame_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic                in_good,
    input  logic                in_bad,
    output logic                word_tick,
    output logic [2*BYTE_W-1:0] out_data,
    output logic                out_vld,
    output logic                out_hi_vld,
    output logic                out_good,
    output logic                out_bad
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              tick;
    logic              consume;
    logic              pend_vld;
    logic [WORD_W-1:0] pend_word;
    logic              pend_hi;
    logic              busy;

    rxp_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rxp_pair #(.BYTE_W(BYTE_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_byte   (in_byte),
        .consume   (consume),
        .pend_vld  (pend_vld),
        .pend_word (pend_word),
        .pend_hi   (pend_hi),
        .busy      (busy)
    );

    rxp_emit #(.BYTE_W(BYTE_W)) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pend_vld   (pend_vld),
        .pend_word  (pend_word),
        .pend_hi    (pend_hi),
        .busy       (busy),
        .in_good    (in_good),
        .in_bad     (in_bad),
        .consume    (consume),
        .out_data   (out_data),
        .out_vld    (out_vld),
        .out_hi_vld (out_hi_vld),
        .out_good   (out_good),
        .out_bad    (out_bad)
    );

    assign word_tick = tick;

endmodule

// File: tb/rxp_frame_packer_bench.sv
module rxp_frame_packer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_good = 1'b0;
    logic        in_bad = 1'b0;
    logic        word_tick;
    logic [15:0] out_data;
    logic        out_vld;
    logic        out_hi_vld;
    logic        out_good;
    logic        out_bad;

    rxp_frame_packer u_rxp_frame_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (in_vld),
        .in_byte    (in_byte),
        .in_good    (in_good),
        .in_bad     (in_bad),
        .word_tick  (word_tick),
        .out_data   (out_data),
        .out_vld    (out_vld),
        .out_hi_vld (out_hi_vld),
        .out_good   (out_good),
        .out_bad    (out_bad)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // frame under test, shared with the monitor
    logic [7:0]  fb [0:15];
    int          cur_len = 0;
    int          cur_kind = 0;
    int          nw = 0;
    int          widx = 0;
    int          pulses = 0;
    int          lo_i = 0;
    bit          prev_vld = 1'b0;
    bit          mon_on = 1'b0;
    bit          have_s = 1'b0;
    logic        prev_tick = 1'b0;
    logic [19:0] last_s = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            chk(word_tick != prev_tick, "R2", "word_tick toggle",
                int'(word_tick), int'(!prev_tick));
            if (!word_tick) begin
                last_s = {out_data, out_vld, out_hi_vld, out_good, out_bad};
                have_s = 1'b1;
                if (out_vld) begin
                    chk(widx < nw, "R7", "word index within frame", widx, nw - 1);
                    if (widx < nw) begin
                        lo_i = 2 * widx;
                        if (widx == 0)
                            chk(out_data[7:0] == fb[0], "R4", "first byte low half",
                                int'(out_data[7:0]), int'(fb[0]));
                        else
                            chk(out_data[7:0] == fb[lo_i], "R3", "low byte",
                                int'(out_data[7:0]), int'(fb[lo_i]));
                        if (lo_i + 1 < cur_len) begin
                            chk(out_hi_vld == 1'b1, "R5", "upper valid on full word",
                                int'(out_hi_vld), 1);
                            chk(out_data[15:8] == fb[lo_i+1], "R3", "high byte",
                                int'(out_data[15:8]), int'(fb[lo_i+1]));
                        end else begin
                            chk(out_hi_vld == 1'b0, "R6", "upper valid on odd tail",
                                int'(out_hi_vld), 0);
                            chk(out_data[15:8] == 8'h00, "R6", "upper bits on odd tail",
                                int'(out_data[15:8]), 0);
                        end
                    end
                    widx++;
                end else if (prev_vld) begin
                    chk(widx == nw, "R7", "words before valid drop", widx, nw);
                    chk(out_hi_vld == 1'b0, "R5", "upper valid drops", int'(out_hi_vld), 0);
                end
                if (out_good || out_bad) begin
                    pulses++;
                    chk(prev_vld && !out_vld, "R8", "verdict in first idle word",
                        int'(prev_vld), 1);
                    chk(!(out_good && out_bad), "R9", "both verdicts", 1, 0);
                    chk(out_bad == (cur_kind != 0), "R9", "bad verdict",
                        int'(out_bad), int'(cur_kind != 0));
                    chk(out_good == (cur_kind == 0), "R8", "good verdict",
                        int'(out_good), int'(cur_kind == 0));
                end
                prev_vld = out_vld;
            end else if (have_s) begin
                chk({out_data, out_vld, out_hi_vld, out_good, out_bad} == last_s,
                    "R2", "mid-word change",
                    int'({out_data, out_vld, out_hi_vld, out_good, out_bad}), int'(last_s));
            end
        end
        prev_tick = word_tick;
    end

    task automatic send(input int len, input int ph, input int kind);
        for (int i = 0; i < 16; i++) fb[i] = 8'((len * 29 + i * 53 + kind * 17 + 7) & 255);
        cur_len  = len;
        cur_kind = kind;
        nw       = (len + 1) / 2;
        widx     = 0;
        pulses   = 0;
        @(negedge clk);
        while (int'(word_tick) != ph) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            in_vld  = 1'b1;
            in_byte = fb[i];
            @(negedge clk);
        end
        in_vld  = 1'b0;
        in_byte = '0;
        in_good = (kind == 0 || kind == 2);
        in_bad  = (kind != 0);
        @(negedge clk);
        in_good = 1'b0;
        in_bad  = 1'b0;
        repeat (14) @(negedge clk);
        chk(pulses == 1, "R8", "verdict count", pulses, 1);
        chk(widx == nw, "R7", "words delivered", widx, nw);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk({word_tick, out_data, out_vld, out_hi_vld, out_good, out_bad} == '0,
            "R1", "outputs in reset",
            int'({word_tick, out_data, out_vld, out_hi_vld, out_good, out_bad}), 0);
        rst_n = 1'b1;
        chk(word_tick == 1'b0 && out_vld == 1'b0 && out_data == '0, "R1",
            "outputs after release", int'(word_tick) + int'(out_vld), 0);
        prev_tick = word_tick;
        @(negedge clk);
        mon_on = 1'b1;
        for (int len = 1; len <= 12; len++)
            for (int ph = 0; ph < 2; ph++)
                for (int kind = 0; kind < 2; kind++)
                    send(len, ph, kind);
        for (int len = 1; len <= 4; len++)
            send(len, len % 2, 2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule